// File: doc/BRIEF.md
# Hexadecimal Floating-Point Adder/Subtractor

This block adds or subtracts two base-16 floating-point operands. Each operand has a sign bit, a 7-bit characteristic that holds the power of sixteen in excess-64 notation, and a fraction made of hex digits with the radix point to the left of the first digit. The block handles a short 32-bit form (six fraction digits) and a long 64-bit form (fourteen fraction digits). The path runs in this order:

- The operand with the smaller characteristic is aligned by whole hex digits.
- The signed fractions are combined. In the short form one extra guard digit is carried.
- A carry out of the fraction is corrected.
- In normalized mode the leading zero digits are removed.
- The fraction is truncated to the final length.

The block produces the result word, a 2-bit condition code and three exception flags. A significance-enable input selects what happens to a zero result fraction. When it is low, the result is forced to true zero. When it is high, the characteristic is kept and a flag is raised.

The datapath is combinational between an input register stage and the outputs. A caller presents both operands and the mode bits, then pulses `start` for one cycle. On the next clock edge the result is captured and `done` is high for one cycle. The outputs then hold until the next `start`.

Top module: `hexfp_addsub`

## Requirements
- R1: Reset clears `done`, `result`, `cond_code` and `exc_flags` to zero. Every cycle in which `start` is sampled high is followed by exactly one cycle with `done` high. Outputs change only on that edge and hold otherwise.
- R2: The word layout is: bit 63 sign, bits 62:56 characteristic, then the fraction digits with the most significant digit first. In long mode bits 55:0 hold fourteen digits. In short mode only bits 63:32 are used, the operands' bits 31:0 are ignored, and `result[31:0]` is zero.
- R3: The operand with the smaller characteristic moves right by the characteristic difference, in whole hex digits. Short mode keeps seven digits (six plus one guard digit) and long mode keeps fourteen. Digits shifted past that width are lost, so a difference of at least the kept width adds nothing.
- R4: `sub_op` inverts the sign of the second operand. Fractions combine as sign and magnitude, and a nonzero result takes the sign of the larger aligned magnitude.
- R5: A carry out of the top fraction digit shifts the fraction right one digit (the carry enters as digit value 1) and adds one to the characteristic.
- R6: With `norm_mode` = 1, a nonzero fraction shifts left until its top digit is nonzero. The characteristic drops by one for each digit shifted.
- R7: With `norm_mode` = 0, leading zero digits stay in the result and unnormalized operands are accepted as they are.
- R8: The result is truncated to six digits (short) or fourteen digits (long), and the guard digit is dropped without rounding.
- R9: When the truncated fraction is zero and `sig_enable` = 0, `result` is all zeros, `cond_code` = 0 and `exc_flags` = 0. At most one flag is ever set.
- R10: When the truncated fraction is zero and `sig_enable` = 1, `result` has sign 0, the intermediate characteristic and a zero fraction. `cond_code` = 0 and `exc_flags` = 3'b001 (bit 0 = significance).
- R11: When normalization would take the characteristic below zero and the fraction is nonzero, `result` is all zeros, `cond_code` = 0 and `exc_flags` = 3'b010 (bit 1 = underflow).
- R12: When the carry correction takes the characteristic above 127 and the fraction is nonzero, the characteristic wraps modulo 128. `exc_flags` = 3'b100 (bit 2 = overflow) and `cond_code` = 3.
- R13: A nonzero result without overflow gives `cond_code` = 1 when its sign is 1 and 2 when its sign is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture a new result on the next edge |
| long_mode | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits 63:32 |
| sub_op | input | 1 | 1 = subtract the second operand |
| norm_mode | input | 1 | 1 = post-normalize the result |
| sig_enable | input | 1 | 1 = keep the characteristic on a zero fraction and flag it |
| a_word | input | 64 | First operand |
| b_word | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 64 | Result word |
| cond_code | output | 2 | 0 zero, 1 negative, 2 positive, 3 overflow |
| exc_flags | output | 3 | {overflow, underflow, significance} |

## Verification
The checker assumes that `start` is a single-cycle pulse and that operands and mode bits are stable in the cycle in which `start` is high. It also copies the mode bits at that edge so that it can judge the word layout of the captured result. The bench drives every input on the falling edge and raises `start` for exactly one cycle per operation. Between operations it changes operands and modes only while `start` is low, which is the case the hold property covers. Each operation's values are chosen so that the alignment distance stays within the cases the requirements describe, including distances exactly at and beyond the kept width.

// File: rtl/hexfp_pkg.sv
package hexfp_pkg;

    localparam int CHAR_W       = 7;
    localparam int DIG_W        = 4;
    localparam int LONG_DIGITS  = 14;
    localparam int SHORT_DIGITS = 6;
    localparam int GUARD_DIGITS = 1;
    localparam int FRAC_W       = LONG_DIGITS * DIG_W;
    localparam int WORD_W       = 1 + CHAR_W + FRAC_W;
    localparam int HALF_W       = WORD_W / 2;
    localparam int LZ_W         = $clog2(LONG_DIGITS + 1);

    typedef logic [FRAC_W-1:0] frac_t;

    typedef struct packed {
        logic              sign;
        logic [CHAR_W-1:0] chr;
        frac_t             frac;
    } hexop_t;

    typedef struct packed {
        logic              sign;
        logic [CHAR_W-1:0] chr;
        logic [FRAC_W:0]   mag;
    } rawsum_t;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic sig;
    } excp_t;

    // Ones over the top ndig hex digits of a fraction.
    function automatic frac_t digit_mask(input int ndig);
        frac_t m;
        m = '0;
        for (int d = 0; d < LONG_DIGITS; d++) begin
            if (d < ndig) m[FRAC_W-1-d*DIG_W -: DIG_W] = '1;
        end
        return m;
    endfunction

    // Number of zero hex digits above the first nonzero one.
    function automatic logic [LZ_W-1:0] lead_zero_digits(input frac_t f);
        logic [LZ_W-1:0] cnt;
        logic            found;
        cnt   = '0;
        found = 1'b0;
        for (int d = 0; d < LONG_DIGITS; d++) begin
            if (!found) begin
                if (f[FRAC_W-1-d*DIG_W -: DIG_W] == '0) cnt = cnt + 1'b1;
                else found = 1'b1;
            end
        end
        return cnt;
    endfunction

    // Right shift by whole digits; distances at or past the width clear it.
    function automatic frac_t shr_digits(input frac_t f, input logic [CHAR_W-1:0] n);
        if (int'(n) >= LONG_DIGITS) return '0;
        return f >> (int'(n) * DIG_W);
    endfunction

    // Short words live in the upper half; the lower half is ignored.
    function automatic hexop_t unpack_word(input logic [WORD_W-1:0] w, input logic long_mode);
        hexop_t o;
        o = w;
        if (!long_mode) begin
            o.frac = '0;
            o.frac[FRAC_W-1:HALF_W] = w[FRAC_W-1:HALF_W];
        end
        return o;
    endfunction

endpackage

// File: rtl/hexfp_align.sv
module hexfp_align
    import hexfp_pkg::*;
#(
    parameter int SHORT_KEEP = SHORT_DIGITS + GUARD_DIGITS,
    parameter int LONG_KEEP  = LONG_DIGITS
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic              long_mode,
    input  logic              negate_b,
    output hexop_t            big_op,
    output hexop_t            small_op,
    output logic              eff_sub
);

    hexop_t            op_a;
    hexop_t            op_b;
    hexop_t            lesser;
    frac_t             work_mask;
    logic [CHAR_W-1:0] distance;
    logic              swap;

    always_comb begin
        work_mask   = long_mode ? digit_mask(LONG_KEEP) : digit_mask(SHORT_KEEP);
        op_a        = unpack_word(a_word, long_mode);
        op_b        = unpack_word(b_word, long_mode);
        op_b.sign   = op_b.sign ^ negate_b;
        swap        = op_b.chr > op_a.chr;
        big_op      = swap ? op_b : op_a;
        lesser      = swap ? op_a : op_b;
        distance    = big_op.chr - lesser.chr;
        small_op    = lesser;
        small_op.frac = shr_digits(lesser.frac, distance) & work_mask;
        eff_sub     = op_a.sign ^ op_b.sign;
    end

endmodule

// File: rtl/hexfp_addmag.sv
module hexfp_addmag
    import hexfp_pkg::*;
(
    input  hexop_t  big_op,
    input  hexop_t  small_op,
    input  logic    eff_sub,
    output rawsum_t sum
);

    always_comb begin
        sum     = '0;
        sum.chr = big_op.chr;
        if (!eff_sub) begin
            sum.mag  = {1'b0, big_op.frac} + {1'b0, small_op.frac};
            sum.sign = big_op.sign;
        end else if (big_op.frac >= small_op.frac) begin
            sum.mag  = {1'b0, big_op.frac - small_op.frac};
            sum.sign = big_op.sign;
        end else begin
            sum.mag  = {1'b0, small_op.frac - big_op.frac};
            sum.sign = small_op.sign;
        end
    end

endmodule

// File: rtl/hexfp_post.sv
module hexfp_post
    import hexfp_pkg::*;
#(
    parameter int SHORT_KEEP  = SHORT_DIGITS + GUARD_DIGITS,
    parameter int SHORT_FINAL = SHORT_DIGITS,
    parameter int LONG_KEEP   = LONG_DIGITS
) (
    input  rawsum_t           sum,
    input  logic              long_mode,
    input  logic              norm_mode,
    input  logic              sig_enable,
    output logic [WORD_W-1:0] word,
    output cc_e               cc,
    output excp_t             excp
);

    localparam int CEXT_W = CHAR_W + 2;

    frac_t              keep_work;
    frac_t              keep_final;
    frac_t              f_carry;
    frac_t              f_norm;
    frac_t              f_trunc;
    logic [CHAR_W:0]    chr_carry;
    logic [CEXT_W-1:0]  chr_norm;
    logic [LZ_W-1:0]    lz;
    logic               ovf_raw;
    logic               unf_raw;

    always_comb begin
        keep_work  = long_mode ? digit_mask(LONG_KEEP) : digit_mask(SHORT_KEEP);
        keep_final = long_mode ? digit_mask(LONG_KEEP) : digit_mask(SHORT_FINAL);

        // carry correction: one digit right, characteristic up by one
        if (sum.mag[FRAC_W]) begin
            f_carry   = {{(DIG_W-1){1'b0}}, sum.mag[FRAC_W:DIG_W]} & keep_work;
            chr_carry = {1'b0, sum.chr} + 1'b1;
        end else begin
            f_carry   = sum.mag[FRAC_W-1:0];
            chr_carry = {1'b0, sum.chr};
        end
        ovf_raw = chr_carry[CHAR_W];

        // post-normalization by whole digits
        lz       = (norm_mode && f_carry != '0) ? lead_zero_digits(f_carry) : '0;
        f_norm   = f_carry << (int'(lz) * DIG_W);
        chr_norm = {1'b0, chr_carry} - {{(CEXT_W-LZ_W){1'b0}}, lz};
        unf_raw  = chr_norm[CEXT_W-1];

        // truncation, guard digit dropped
        f_trunc = f_norm & keep_final;

        word = '0;
        cc   = CC_ZERO;
        excp = '0;
        if (f_trunc == '0) begin
            if (sig_enable) begin
                word     = {1'b0, chr_carry[CHAR_W-1:0], frac_t'(0)};
                excp.sig = 1'b1;
            end
        end else if (unf_raw) begin
            excp.unf = 1'b1;
        end else begin
            word     = {sum.sign, chr_norm[CHAR_W-1:0], f_trunc};
            excp.ovf = ovf_raw;
            if (ovf_raw)       cc = CC_OVF;
            else if (sum.sign) cc = CC_NEG;
            else               cc = CC_POS;
        end
    end

endmodule

// File: rtl/hexfp_addsub.sv
module hexfp_addsub
    import hexfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              long_mode,
    input  logic              sub_op,
    input  logic              norm_mode,
    input  logic              sig_enable,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic [1:0]        cond_code,
    output logic [2:0]        exc_flags
);

    hexop_t            big_op;
    hexop_t            small_op;
    logic              eff_sub;
    rawsum_t           raw;
    logic [WORD_W-1:0] word_d;
    cc_e               cc_d;
    excp_t             excp_d;

    hexfp_align u_align (
        .a_word    (a_word),
        .b_word    (b_word),
        .long_mode (long_mode),
        .negate_b  (sub_op),
        .big_op    (big_op),
        .small_op  (small_op),
        .eff_sub   (eff_sub)
    );

    hexfp_addmag u_addmag (
        .big_op   (big_op),
        .small_op (small_op),
        .eff_sub  (eff_sub),
        .sum      (raw)
    );

    hexfp_post u_post (
        .sum        (raw),
        .long_mode  (long_mode),
        .norm_mode  (norm_mode),
        .sig_enable (sig_enable),
        .word       (word_d),
        .cc         (cc_d),
        .excp       (excp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            result    <= '0;
            cond_code <= '0;
            exc_flags <= '0;
        end else begin
            done <= start;
            if (start) begin
                result    <= word_d;
                cond_code <= cc_d;
                exc_flags <= excp_d;
            end
        end
    end

endmodule

// File: rtl/hexfp_addsub_chk.sv
module hexfp_addsub_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        long_mode,
    input logic        norm_mode,
    input logic        done,
    input logic [63:0] result,
    input logic [1:0]  cond_code,
    input logic [2:0]  exc_flags
);

    logic long_q;
    logic norm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            long_q <= 1'b0;
            norm_q <= 1'b0;
        end else if (start) begin
            long_q <= long_mode;
            norm_q <= norm_mode;
        end
    end

    a_r1_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(cond_code) && $stable(exc_flags)));

    a_r2_short_low_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !long_q) |-> (result[31:0] == 32'h0));

    a_r6_top_digit: assert property (@(posedge clk) disable iff (rst)
        (done && norm_q && (cond_code == 2'd1 || cond_code == 2'd2)) |-> (result[55:52] != 4'h0));

    a_r9_zero_sign: assert property (@(posedge clk) disable iff (rst)
        (done && result[55:0] == 56'h0) |-> (cond_code == 2'd0 && !result[63]));

    a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(exc_flags) <= 1));

    a_r10_sig_zero: assert property (@(posedge clk) disable iff (rst)
        (done && exc_flags[0]) |-> (result[55:0] == 56'h0 && !result[63] && cond_code == 2'd0));

    a_r11_unf_zero: assert property (@(posedge clk) disable iff (rst)
        (done && exc_flags[1]) |-> (result == 64'h0 && cond_code == 2'd0));

    a_r12_ovf_cc: assert property (@(posedge clk) disable iff (rst)
        (done && exc_flags[2]) |-> (cond_code == 2'd3));

    a_r13_cc_sign: assert property (@(posedge clk) disable iff (rst)
        (done && (cond_code == 2'd1 || cond_code == 2'd2)) |-> (result[63] == (cond_code == 2'd1)));

endmodule

bind hexfp_addsub hexfp_addsub_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .long_mode (long_mode),
    .norm_mode (norm_mode),
    .done      (done),
    .result    (result),
    .cond_code (cond_code),
    .exc_flags (exc_flags)
);

// File: tb/hexfp_addsub_tb.sv
module hexfp_addsub_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 20;

    // mode = {long, sub, norm, sig}
    typedef struct packed {
        logic [3:0]  mode;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic [1:0]  cc;
        logic [2:0]  fl;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'b0010, 64'h41100000_00000000, 64'h41100000_00000000, 64'h41200000_00000000, 2'd2, 3'b000, 4'd4},  // R4 plain add
        '{4'b0010, 64'h41800000_00000000, 64'h41800000_00000000, 64'h42100000_00000000, 2'd2, 3'b000, 4'd5},  // R5 carry
        '{4'b0010, 64'h42100000_DEADBEEF, 64'h41100000_12345678, 64'h42110000_00000000, 2'd2, 3'b000, 4'd2},  // R2 low half ignored
        '{4'b0110, 64'h41100000_00000000, 64'h40FFFFFF_00000000, 64'h3B100000_00000000, 2'd2, 3'b000, 4'd3},  // R3 guard digit
        '{4'b0100, 64'h41100000_00000000, 64'h40FFFFFF_00000000, 64'h00000000_00000000, 2'd0, 3'b000, 4'd7},  // R7 unnorm to zero
        '{4'b0101, 64'h41100000_00000000, 64'h40FFFFFF_00000000, 64'h41000000_00000000, 2'd0, 3'b001, 4'd10}, // R10 significance
        '{4'b0110, 64'h41100000_00000000, 64'h41300000_00000000, 64'hC1200000_00000000, 2'd1, 3'b000, 4'd13}, // R13 negative
        '{4'b0110, 64'hC2500000_00000000, 64'hC2500000_00000000, 64'h00000000_00000000, 2'd0, 3'b000, 4'd9},  // R9 true zero
        '{4'b0111, 64'hC2500000_00000000, 64'hC2500000_00000000, 64'h42000000_00000000, 2'd0, 3'b001, 4'd10}, // R10 kept char
        '{4'b0010, 64'h7F800000_00000000, 64'h7F800000_00000000, 64'h00100000_00000000, 2'd3, 3'b100, 4'd12}, // R12 overflow
        '{4'b0110, 64'h00100000_00000000, 64'h000FFFFF_00000000, 64'h00000000_00000000, 2'd0, 3'b010, 4'd11}, // R11 underflow
        '{4'b0000, 64'h41010000_00000000, 64'h41020000_00000000, 64'h41030000_00000000, 2'd2, 3'b000, 4'd7},  // R7 zeros kept
        '{4'b0010, 64'h41010000_00000000, 64'h41020000_00000000, 64'h40300000_00000000, 2'd2, 3'b000, 4'd6},  // R6 normalize
        '{4'b0010, 64'h50123456_00000000, 64'h41FFFFFF_00000000, 64'h50123456_00000000, 2'd2, 3'b000, 4'd3},  // R3 past width
        '{4'b0010, 64'h46100000_00000000, 64'h40F00000_00000000, 64'h46100000_00000000, 2'd2, 3'b000, 4'd8},  // R8 no rounding
        '{4'b1010, 64'h41100000_00000000, 64'h3F100000_00000000, 64'h41101000_00000000, 2'd2, 3'b000, 4'd3},  // R3 long align
        '{4'b1010, 64'h4E100000_00000000, 64'h41100000_00000000, 64'h4E100000_00000001, 2'd2, 3'b000, 4'd3},  // R3 long last digit
        '{4'b1110, 64'h42100000_00000000, 64'hC1100000_00000000, 64'h42110000_00000000, 2'd2, 3'b000, 4'd4},  // R4 sub of negative
        '{4'b1010, 64'hFF800000_00000000, 64'hFF800000_00000000, 64'h80100000_00000000, 2'd3, 3'b100, 4'd12}, // R12 long wrap
        '{4'b1000, 64'h41001000_00000000, 64'h41002000_00000000, 64'h41003000_00000000, 2'd2, 3'b000, 4'd7}   // R7 long unnorm
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        long_mode = 1'b0;
    logic        sub_op = 1'b0;
    logic        norm_mode = 1'b0;
    logic        sig_enable = 1'b0;
    logic [63:0] a_word = '0;
    logic [63:0] b_word = '0;
    logic        done;
    logic [63:0] result;
    logic [1:0]  cond_code;
    logic [2:0]  exc_flags;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexfp_addsub u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .long_mode  (long_mode),
        .sub_op     (sub_op),
        .norm_mode  (norm_mode),
        .sig_enable (sig_enable),
        .a_word     (a_word),
        .b_word     (b_word),
        .done       (done),
        .result     (result),
        .cond_code  (cond_code),
        .exc_flags  (exc_flags)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] mode, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        {long_mode, sub_op, norm_mode, sig_enable} = mode;
        a_word = a;
        b_word = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(done == 1'b0, "R1 reset done", {63'h0, done}, 64'h0);
        check(result == 64'h0, "R1 reset result", result, 64'h0);
        check({cond_code, exc_flags} == 5'h0, "R1 reset cc/flags", {59'h0, cond_code, exc_flags}, 64'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].mode, VECS[i].a, VECS[i].b);
            check(done == 1'b1, $sformatf("R1 done vec %0d", i), {63'h0, done}, 64'h1);
            check(result == VECS[i].res, $sformatf("R%0d result vec %0d", VECS[i].req, i),
                  result, VECS[i].res);
            check(cond_code == VECS[i].cc, $sformatf("R%0d cc vec %0d", VECS[i].req, i),
                  {62'h0, cond_code}, {62'h0, VECS[i].cc});
            check(exc_flags == VECS[i].fl, $sformatf("R%0d flags vec %0d", VECS[i].req, i),
                  {61'h0, exc_flags}, {61'h0, VECS[i].fl});
        end

        // R1 done is one cycle only, outputs hold while inputs move without start
        held = result;
        for (int k = 0; k < 3; k++) begin
            a_word    = 64'h41900000_00000000 + 64'(k);
            b_word    = 64'h42700000_00000000;
            long_mode = k[0];
            norm_mode = 1'b1;
            @(negedge clk);
            check(done == 1'b0, "R1 done dropped", {63'h0, done}, 64'h0);
            check(result == held, "R1 result held", result, held);
        end

        // R1 back-to-back starts each give a done
        @(negedge clk);
        {long_mode, sub_op, norm_mode, sig_enable} = 4'b0010;
        a_word = 64'h41100000_00000000;
        b_word = 64'h41100000_00000000;
        start  = 1'b1;
        @(negedge clk);
        check(done == 1'b1 && result == 64'h41200000_00000000, "R1 first of pair", result, 64'h41200000_00000000);
        b_word = 64'h41300000_00000000;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && result == 64'h41400000_00000000, "R1 second of pair", result, 64'h41400000_00000000);

        // R1 reset clears a held result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(result == 64'h0 && done == 1'b0, "R1 reset clears", result, 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule